// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked host read and write an asynchronous static RAM of 128K bytes. The host issues one access at a time with a single-cycle request pulse, giving a write flag, an address and, for writes, a data byte. The controller then sequences the memory's active-low chip, write and output enable strobes. It owns the tri-state control of the shared 8-bit data bus, captures read data at the end of the access window and returns a one-cycle done pulse. When no access is in progress it holds chip enable high, which leaves the memory in standby.

The number of wait cycles in each phase is worked out at elaboration from the clock period and the memory's timing figures, rounding each ratio up. The figures are the address, chip-enable and output-enable access times, the time the memory takes to release the bus, and the write pulse width. The defaults describe a 10 ns memory on a 5 ns clock: 2 cycles of read window, 2 cycles of release time and 2 cycles of write pulse. A faster clock adds cycles, and a slower memory adds cycles.

A write that follows a read closely waits until the memory has had the full release time since output enable rose. Only then does the controller drive the bus. A write that follows a long idle period starts at once.

Top module: `sram_ctrl`

## Requirements
- R1: During and straight after reset, all three strobes (mem_ce_n, mem_we_n, mem_oe_n) are high, rsp_done is low, and the controller does not drive mem_dq (it reads as high-impedance while the memory is also disabled).
- R2: mem_ce_n is high in every cycle in which no access is in progress. In the cycle rsp_done is high, all three strobes are high.
- R3: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly RD_WAIT cycles. RD_WAIT is the largest of ceil(T_ADDR_ACC_NS/CLK_NS), ceil(T_CE_ACC_NS/CLK_NS) and ceil(T_OE_ACC_NS/CLK_NS), with a minimum of 1, and is 2 by default. The byte on mem_dq at the end of that window appears on rsp_rdata together with rsp_done, and rsp_rdata then stays unchanged until the next read completes, even across writes.
- R4: A write holds mem_we_n low for exactly WP_WAIT = max(1, ceil(T_WPULSE_NS/CLK_NS)) cycles (2 by default), with mem_ce_n low and mem_oe_n high. The write byte is on mem_dq in every cycle mem_we_n is low, and it is still driven when mem_we_n rises.
- R5: The controller starts driving mem_dq no sooner than HIZ_WAIT = max(1, ceil(T_HIZ_NS/CLK_NS)) clock edges after the edge at which mem_oe_n rose (2 by default).
- R6: The controller never drives mem_dq while mem_oe_n is low. In every such cycle mem_dq carries exactly the memory's output byte.
- R7: mem_addr does not change while mem_ce_n stays low, and the driven write byte does not change while the controller keeps driving.
- R8: rsp_done is high for exactly one cycle per accepted request. A request pulse that arrives while an access is in progress is ignored and leaves the memory contents unchanged.
- R9: For a read accepted at clock edge E, rsp_done is high in the cycle after edge E+RD_WAIT.
- R10: For a write accepted at edge E, rsp_done is high in the cycle after edge E+WP_WAIT+2+X. X = max(0, HIZ_WAIT-1-Q), where Q is the number of edges after the one at which mem_oe_n last rose and before E. X is therefore 1 by default for a write requested in the done cycle of a read, and 0 once one idle cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rsp_rdata | output | DATA_W | Last byte read, held until the next read completes |
| rsp_done | output | 1 | One-cycle pulse when an access ends |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
The two functions that can fall in the same cycle are the end of a read and the acceptance of a new write. Read data capture and the release of output enable fall at one edge, and the next request can be presented in the very done cycle, so bus turnaround overlaps the tail of the read. The bench provokes this by issuing a write in the done cycle of a read, and again after one idle cycle. It also injects a request pulse in the middle of a busy read. It judges the outcome cycle by cycle against a behavioural memory model: the done cycle must match the computed latency including any extra turnaround cycle, mem_dq must equal the model's byte whenever output enable is low, and the injected write must leave no trace when the address is read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR_TURN,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_quiet_cnt.sv
module sram_quiet_cnt #(
   parameter int LIMIT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic ready
);

   localparam int             QW  = $clog2(LIMIT + 2);
   localparam logic [QW-1:0]  LIM = QW'(LIMIT);

   logic [QW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quiet_q <= LIM;
      else if (!oe_n)
         quiet_q <= '0;
      else if (quiet_q < LIM)
         quiet_q <= quiet_q + 1'b1;
   end

   assign ready = (quiet_q >= LIM);

endmodule

// File: rtl/sram_dq_io.sv
module sram_dq_io #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (capture)
         rdata <= dq_in;
   end

   // R3: the returned byte only moves after a capture edge
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(rdata));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int              ADDR_W  = 17,
   parameter int              DATA_W  = 8,
   parameter int              CNT_W   = 2,
   parameter logic [CNT_W-1:0] RD_LOAD = '0,
   parameter logic [CNT_W-1:0] WP_LOAD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              quiet_ok,
   input  logic              cnt_zero,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              capture,
   output logic              ce_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              drive_en,
   output logic              done
);

   seq_state_t state_q;

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: if (req && !req_wr) begin
            cnt_load = 1'b1;
            cnt_val  = RD_LOAD;
         end
         ST_WR_SETUP: begin
            cnt_load = 1'b1;
            cnt_val  = WP_LOAD;
         end
         ST_RD: capture = cnt_zero;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ce_n     <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         addr     <= '0;
         wdata    <= '0;
         drive_en <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (req) begin
               addr <= req_addr;
               ce_n <= 1'b0;
               if (!req_wr) begin
                  oe_n    <= 1'b0;
                  state_q <= ST_RD;
               end else begin
                  wdata <= req_wdata;
                  if (quiet_ok) begin
                     drive_en <= 1'b1;
                     state_q  <= ST_WR_SETUP;
                  end else begin
                     state_q <= ST_WR_TURN;
                  end
               end
            end
            ST_RD: if (cnt_zero) begin
               ce_n    <= 1'b1;
               oe_n    <= 1'b1;
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_WR_TURN: if (quiet_ok) begin
               drive_en <= 1'b1;
               state_q  <= ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
               we_n    <= 1'b0;
               state_q <= ST_WR_PULSE;
            end
            ST_WR_PULSE: if (cnt_zero) begin
               we_n    <= 1'b1;
               state_q <= ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
               drive_en <= 1'b0;
               ce_n     <= 1'b1;
               done     <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: completion is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: the done cycle finds the memory in standby
   assert_done_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ce_n && we_n && oe_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_NS        = 5,
   parameter int T_ADDR_ACC_NS = 10,
   parameter int T_CE_ACC_NS   = 10,
   parameter int T_OE_ACC_NS   = 6,
   parameter int T_HIZ_NS      = 6,
   parameter int T_WPULSE_NS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n
);

   localparam int RD_WAIT  = max_int(1, max_int(ceil_div(T_OE_ACC_NS, CLK_NS),
                             max_int(ceil_div(T_ADDR_ACC_NS, CLK_NS),
                                     ceil_div(T_CE_ACC_NS, CLK_NS))));
   localparam int HIZ_WAIT = max_int(1, ceil_div(T_HIZ_NS, CLK_NS));
   localparam int WP_WAIT  = max_int(1, ceil_div(T_WPULSE_NS, CLK_NS));
   localparam int CNT_W    = $clog2(max_int(RD_WAIT, WP_WAIT) + 1);
   localparam int GAP_W    = $clog2(HIZ_WAIT + 1);
   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_WAIT - 1);
   localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(HIZ_WAIT);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_ctrl: CLK_NS must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_ctrl: bus widths must be positive");
   end
   if (T_ADDR_ACC_NS < 0 || T_CE_ACC_NS < 0 || T_OE_ACC_NS < 0 ||
       T_HIZ_NS < 0 || T_WPULSE_NS < 0) begin : g_bad_time
      $error("sram_ctrl: timing figures must not be negative");
   end

   logic              quiet_ok;
   logic              cnt_zero;
   logic              cnt_load;
   logic [CNT_W-1:0]  cnt_val;
   logic              capture;
   logic              drive_en;
   logic [DATA_W-1:0] wdata_q;

   sram_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .RD_LOAD(RD_LOAD),
      .WP_LOAD(WP_LOAD)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_wr   (req_wr),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .quiet_ok (quiet_ok),
      .cnt_zero (cnt_zero),
      .cnt_load (cnt_load),
      .cnt_val  (cnt_val),
      .capture  (capture),
      .ce_n     (mem_ce_n),
      .we_n     (mem_we_n),
      .oe_n     (mem_oe_n),
      .addr     (mem_addr),
      .wdata    (wdata_q),
      .drive_en (drive_en),
      .done     (rsp_done)
   );

   sram_wait_cnt #(.CNT_W(CNT_W)) wait_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load),
      .load_val(cnt_val),
      .zero    (cnt_zero)
   );

   sram_quiet_cnt #(.LIMIT(HIZ_WAIT - 1)) quiet_i (
      .clk  (clk),
      .rst_n(rst_n),
      .oe_n (mem_oe_n),
      .ready(quiet_ok)
   );

   sram_dq_io #(.DATA_W(DATA_W)) dq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(capture),
      .dq_in  (mem_dq),
      .rdata  (rsp_rdata)
   );

   for (genvar b = 0; b < DATA_W; b++) begin : g_dq
      assign mem_dq[b] = drive_en ? wdata_q[b] : 1'bz;
   end

   // Edges elapsed since output enable was last released, for the R5 check
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= GAP_SAT;
      else if (!mem_oe_n)
         gap_q <= '0;
      else if (gap_q < GAP_SAT)
         gap_q <= gap_q + 1'b1;
   end

   assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_en) |-> (gap_q >= GAP_SAT));

   assert_no_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_en && !mem_oe_n));

   assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

   assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (drive_en && !mem_ce_n && mem_oe_n));

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && $past(drive_en)) |-> $stable(wdata_q));

endmodule

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

   localparam int AW    = 17;
   localparam int DW    = 8;
   localparam int RD_W  = 2;   // max of ceil(10/5), ceil(10/5), ceil(6/5)
   localparam int HIZ_W = 2;   // ceil(6/5)
   localparam int WP_W  = 2;   // ceil(8/5)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_done;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;
   logic          mem_ce_n, mem_we_n, mem_oe_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .mem_addr(mem_addr), .mem_dq(mem_dq),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   // ---------------- behavioural memory ----------------
   logic [DW-1:0] cells [int];
   logic [DW-1:0] shadow [int];
   logic [DW-1:0] mem_q;
   logic          mem_drv;

   function automatic logic [DW-1:0] fill(input logic [AW-1:0] a);
      return a[7:0] ^ {a[15:9], a[16]} ^ 8'h3C;
   endfunction

   function automatic logic [DW-1:0] cell_rd(input logic [AW-1:0] a);
      if (cells.exists(int'(a))) return cells[int'(a)];
      return fill(a);
   endfunction

   function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
      if (shadow.exists(int'(a))) return shadow[int'(a)];
      return fill(a);
   endfunction

   assign mem_drv = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mem_dq  = mem_drv ? mem_q : 8'hzz;

   always @(mem_addr or mem_oe_n or mem_ce_n) mem_q = cell_rd(mem_addr);

   always @(posedge mem_we_n)
      if (rst_n && mem_ce_n == 1'b0) cells[int'(mem_addr)] = mem_dq;

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   // edges since output enable was last released, tracked from the pins
   int q_p = 1000;
   always @(posedge clk) begin
      if (!rst_n) q_p = 1000;
      else if (mem_oe_n == 1'b0) q_p = 0;
      else if (q_p < 1000) q_p = q_p + 1;
   end

   bit            busy = 1'b0;
   logic [DW-1:0] cur_wd = '0;
   int            oe_run = 0;
   int            we_run = 0;
   logic          prev_ce_n = 1'b1;
   logic [AW-1:0] prev_addr = '0;

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_oe_n) chk(mem_dq === mem_q, "R6 bus while output enable low", int'(mem_dq), int'(mem_q));
         if (!mem_we_n) begin
            chk(mem_dq === cur_wd, "R4 write byte on bus", int'(mem_dq), int'(cur_wd));
            chk(!mem_ce_n && mem_oe_n, "R4 strobes during write pulse", {mem_ce_n, mem_oe_n}, 2'b01);
         end
         if (!busy) chk(mem_ce_n === 1'b1, "R2 standby when idle", int'(mem_ce_n), 1);
         if (!mem_ce_n && !prev_ce_n) chk(mem_addr === prev_addr, "R7 address stable", int'(mem_addr), int'(prev_addr));
         if (!mem_oe_n) oe_run++;
         else if (oe_run > 0) begin
            chk(oe_run == RD_W, "R3 read window length", oe_run, RD_W);
            oe_run = 0;
         end
         if (!mem_we_n) we_run++;
         else if (we_run > 0) begin
            chk(we_run == WP_W, "R4 write pulse length", we_run, WP_W);
            we_run = 0;
         end
         prev_ce_n = mem_ce_n;
         prev_addr = mem_addr;
      end
   end

   // one access; returns at the negedge where rsp_done is seen
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit inject, input logic [AW-1:0] ia);
      int  lat;
      int  extra;
      bit  early;
      extra = 0;
      if (wr) begin
         extra = (HIZ_W - 1 > q_p) ? (HIZ_W - 1 - q_p) : 0;
         lat = WP_W + 2 + extra;
         cur_wd = d;
      end else begin
         lat = RD_W;
      end
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; busy = 1'b1;
      early = 1'b0;
      for (int i = 1; i <= lat + 1; i++) begin
         @(negedge clk);
         if (i == 1) begin
            req = 1'b0;
            if (inject) begin
               req = 1'b1; req_wr = 1'b1; req_addr = ia; req_wdata = ~d;
            end
         end else if (i == 2) begin
            req = 1'b0;
         end
         if (i <= lat && rsp_done) early = 1'b1;
      end
      if (wr) chk(rsp_done && !early, (extra > 0) ? "R10 write latency after read" : "R10 write latency",
                  {early, rsp_done}, 1);
      else chk(rsp_done && !early, "R9 read latency", {early, rsp_done}, 1);
      if (wr) shadow[int'(a)] = d;
      else chk(rsp_rdata === exp_rd(a), "R3 read data", int'(rsp_rdata), int'(exp_rd(a)));
      busy = 1'b0;
   endtask

   // watchdog
   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   logic [AW-1:0] addrs [8];
   logic [DW-1:0] held;

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk({mem_ce_n, mem_we_n, mem_oe_n} === 3'b111, "R1 strobes after reset",
          {mem_ce_n, mem_we_n, mem_oe_n}, 7);
      chk(rsp_done === 1'b0, "R1 done low after reset", int'(rsp_done), 0);
      chk(mem_dq === 8'hzz, "R1 bus released after reset", int'(mem_dq), 0);

      // addresses including both ends of the range
      addrs[0] = '0;
      addrs[1] = 17'h1FFFF;
      for (int k = 2; k < 8; k++) addrs[k] = AW'((k * 40503 + 4660) % 131072);

      // writes after idle, then read back
      for (int k = 0; k < 8; k++) access(1'b1, addrs[k], DW'(k * 37 + 5), 1'b0, '0);
      for (int k = 0; k < 8; k++) access(1'b0, addrs[k], '0, 1'b0, '0);

      // unwritten address returns the model's fill byte
      access(1'b0, 17'h15555, '0, 1'b0, '0);

      // R10: write requested in the done cycle of a read
      access(1'b0, addrs[2], '0, 1'b0, '0);
      access(1'b1, addrs[3], 8'hA5, 1'b0, '0);
      access(1'b0, addrs[3], '0, 1'b0, '0);

      // R10: one idle cycle after a read, no extra turnaround
      access(1'b0, addrs[4], '0, 1'b0, '0);
      @(negedge clk);
      access(1'b1, addrs[5], 8'h5A, 1'b0, '0);
      access(1'b1, addrs[6], 8'hC3, 1'b0, '0);
      access(1'b0, addrs[5], '0, 1'b0, '0);
      access(1'b0, addrs[6], '0, 1'b0, '0);

      // R8: request while busy is ignored
      access(1'b0, addrs[1], '0, 1'b1, addrs[7]);
      @(negedge clk);
      chk(rsp_done === 1'b0, "R8 no second done", int'(rsp_done), 0);
      access(1'b0, addrs[7], '0, 1'b0, '0);

      // R3: read data held across a write
      held = rsp_rdata;
      access(1'b1, addrs[0], 8'h77, 1'b0, '0);
      chk(rsp_rdata === held, "R3 read data held across write", int'(rsp_rdata), int'(held));
      repeat (5) @(negedge clk);
      chk(rsp_rdata === held, "R3 read data held while idle", int'(rsp_rdata), int'(held));
      chk(mem_ce_n === 1'b1, "R2 standby after accesses", int'(mem_ce_n), 1);
      access(1'b0, addrs[0], '0, 1'b0, '0);
      repeat (3) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule